// File: doc/BRIEF.md
# Two-Level Bitmap Priority Ready List

This block keeps track of which task priorities are ready to run in a priority-driven kernel. It holds one bit per priority level. The levels sit in a table of equal-sized rows. A summary register beside the table carries one bit per row, and that bit is set whenever any bit of its row is set. Software-visible kernel actions arrive as single-cycle strobes: mark a priority ready, mark it not ready, enter or leave an interrupt, and lock or unlock the scheduler.

From the registered state the block drives the number of the most urgent ready priority, where a smaller number is more urgent. The search is two-level. It first finds the lowest set summary bit and then the lowest set bit in that row. The block compares the result with the priority the kernel reports as running, and it raises a switch request when they differ. The request stays low while an interrupt nesting count or a scheduler lock count is nonzero.

The least urgent level is reserved for an idle task, so at least one priority is always ready. The level just above it is conventionally given to a statistics task, but the block treats that level like any other.

Top module: `ready_list_sched`

## Requirements
- R1: A `set_en` strobe with priority `set_prio` marks that priority ready from the clock edge that samples it. `top_prio` reflects the change immediately after that edge.
- R2: After every edge, `grp_map[g]` is 1 exactly when some priority in row g is ready. Clearing the last ready priority of a row drops its summary bit on the same edge.
- R3: Priority p lives in row p / GROUP_W at bit p % GROUP_W. The upper bits of p are the row index and the lower log2(GROUP_W) bits are the bit index. `top_prio` is the smallest ready priority number, and `top_valid` is 1 whenever any priority is ready.
- R4: After reset only the idle priority (GROUPS*GROUP_W-1) is ready. A clear aimed at the idle priority is ignored, so the idle priority is always ready.
- R5: When `set_en` and `clr_en` name the same priority in one cycle, that priority ends up not ready. When they name different priorities, both actions take effect.
- R6: `switch_req` is 1 when `top_prio` differs from `run_prio` and both counts are zero. It is 0 when `top_prio` equals `run_prio`.
- R7: The scheduler lock count rises on `lock_req` and falls on `unlock_req`. A cycle with both strobes leaves it unchanged. An unlock at zero is ignored, and a lock at the maximum value (2^CNT_W-1) saturates. While the count is nonzero, `switch_req` is 0.
- R8: The interrupt nesting count follows the same rules as R7, driven by `int_enter` and `int_exit`. While it is nonzero, `switch_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_en | input | 1 | Mark `set_prio` ready |
| set_prio | input | PRIO_W | Priority to mark ready |
| clr_en | input | 1 | Mark `clr_prio` not ready |
| clr_prio | input | PRIO_W | Priority to mark not ready |
| run_prio | input | PRIO_W | Priority currently running |
| lock_req | input | 1 | Scheduler lock strobe |
| unlock_req | input | 1 | Scheduler unlock strobe |
| int_enter | input | 1 | Interrupt entry strobe |
| int_exit | input | 1 | Interrupt exit strobe |
| grp_map | output | GROUPS | Row summary bits |
| top_prio | output | PRIO_W | Most urgent ready priority |
| top_valid | output | 1 | Some priority is ready |
| switch_req | output | 1 | Context switch needed |

## Verification
The bench builds the block with GROUPS=4, GROUP_W=4 and CNT_W=3. That gives 16 priorities and counts that saturate at 7. The small table lets the bench try every ordered pair of non-idle priorities, so every row-to-row and within-row ordering of the two-level search is covered, along with every row's summary bit rising and falling. The 3-bit counts let the bench reach saturation and return to zero in a few cycles, so a wrapping counter or an underflowing unlock would show up as an early or late switch request.

// File: rtl/rl_pkg.sv
`timescale 1ns/1ps
package rl_pkg;
    localparam int unsigned DEF_GROUPS  = 8;
    localparam int unsigned DEF_GROUP_W = 8;
    localparam int unsigned DEF_CNT_W   = 8;

    typedef struct packed {
        logic set_hit;
        logic clr_hit;
    } rl_strobe_t;
endpackage

// File: rtl/rl_bitmap.sv
`timescale 1ns/1ps
module rl_bitmap #(
    parameter int unsigned GROUPS  = rl_pkg::DEF_GROUPS,
    parameter int unsigned GROUP_W = rl_pkg::DEF_GROUP_W,
    parameter int unsigned PRIO_W  = $clog2(GROUPS * GROUP_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [PRIO_W-1:0]           set_prio,
    input  logic                        clr_en,
    input  logic [PRIO_W-1:0]           clr_prio,
    output logic [GROUPS-1:0]           grp_map,
    output logic [GROUPS*GROUP_W-1:0]   ready_flat
);
    localparam int unsigned NUM   = GROUPS * GROUP_W;
    localparam int unsigned BIT_W = $clog2(GROUP_W);
    localparam logic [PRIO_W-1:0] IDLE = PRIO_W'(NUM - 1);

    typedef struct packed {
        logic [GROUPS-1:0]              grp;
        logic [GROUPS-1:0][GROUP_W-1:0] tbl;
    } map_t;

    map_t map_d, map_q;
    rl_pkg::rl_strobe_t stb;

    always_comb begin
        map_d       = map_q;
        stb.set_hit = set_en;
        stb.clr_hit = clr_en && (clr_prio != IDLE);
        if (stb.set_hit)
            map_d.tbl[set_prio[PRIO_W-1:BIT_W]][set_prio[BIT_W-1:0]] = 1'b1;
        // clear is applied last so it wins over a set of the same level
        if (stb.clr_hit)
            map_d.tbl[clr_prio[PRIO_W-1:BIT_W]][clr_prio[BIT_W-1:0]] = 1'b0;
        for (int g = 0; g < int'(GROUPS); g++)
            map_d.grp[g] = |map_d.tbl[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q                           <= '0;
            map_q.tbl[GROUPS-1][GROUP_W-1]  <= 1'b1;
            map_q.grp[GROUPS-1]             <= 1'b1;
        end else begin
            map_q <= map_d;
        end
    end

    assign grp_map    = map_q.grp;
    assign ready_flat = map_q.tbl;

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_sum_chk
            p_group_summary_r2: assert property (@(posedge clk) disable iff (!rst_n)
                grp_map[g] == (|ready_flat[g*GROUP_W +: GROUP_W]));
        end
    endgenerate

    p_idle_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready_flat[NUM-1]);

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en && set_prio == clr_prio && clr_prio != IDLE)
        |=> !ready_flat[$past(clr_prio)]);

    p_set_marks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !(clr_en && clr_prio == set_prio)) |=> ready_flat[$past(set_prio)]);
endmodule

// File: rtl/rl_encoder.sv
`timescale 1ns/1ps
module rl_encoder #(
    parameter int unsigned GROUPS  = rl_pkg::DEF_GROUPS,
    parameter int unsigned GROUP_W = rl_pkg::DEF_GROUP_W,
    parameter int unsigned PRIO_W  = $clog2(GROUPS * GROUP_W)
) (
    input  logic [GROUPS-1:0]           grp_map,
    input  logic [GROUPS*GROUP_W-1:0]   ready_flat,
    output logic [PRIO_W-1:0]           top_prio,
    output logic                        top_valid
);
    localparam int unsigned BIT_W = $clog2(GROUP_W);
    localparam int unsigned GRP_W = PRIO_W - BIT_W;

    logic [GRP_W-1:0]   g_sel;
    logic [BIT_W-1:0]   b_sel;
    logic [GROUP_W-1:0] row;

    // level one: lowest set summary bit picks the row
    always_comb begin
        g_sel = '0;
        for (int i = int'(GROUPS) - 1; i >= 0; i--)
            if (grp_map[i]) g_sel = GRP_W'(i);
    end

    assign row = ready_flat[g_sel*GROUP_W +: GROUP_W];

    // level two: lowest set bit inside the chosen row
    always_comb begin
        b_sel = '0;
        for (int j = int'(GROUP_W) - 1; j >= 0; j--)
            if (row[j]) b_sel = BIT_W'(j);
    end

    assign top_prio  = {g_sel, b_sel};
    assign top_valid = |grp_map;
endmodule

// File: rtl/rl_nest_ctr.sv
`timescale 1ns/1ps
module rl_nest_ctr #(
    parameter int unsigned CNT_W = rl_pkg::DEF_CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic busy
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
        if (dec && !inc && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // shared by the lock count (R7) and the nesting count (R8)
    p_dec_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dec && !inc) |=> !busy);
    p_inc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt_q != CMAX) |=> cnt_q == $past(cnt_q) + 1'b1);
    p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt_q == CMAX) |=> cnt_q == CMAX);
endmodule

// File: rtl/ready_list_sched.sv
`timescale 1ns/1ps
module ready_list_sched #(
    parameter int unsigned GROUPS  = rl_pkg::DEF_GROUPS,
    parameter int unsigned GROUP_W = rl_pkg::DEF_GROUP_W,
    parameter int unsigned CNT_W   = rl_pkg::DEF_CNT_W,
    parameter int unsigned PRIO_W  = $clog2(GROUPS * GROUP_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [PRIO_W-1:0] set_prio,
    input  logic              clr_en,
    input  logic [PRIO_W-1:0] clr_prio,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              lock_req,
    input  logic              unlock_req,
    input  logic              int_enter,
    input  logic              int_exit,
    output logic [GROUPS-1:0] grp_map,
    output logic [PRIO_W-1:0] top_prio,
    output logic              top_valid,
    output logic              switch_req
);
    localparam int unsigned NUM = GROUPS * GROUP_W;

    logic [NUM-1:0] ready_flat;
    logic           lock_busy, nest_busy;

    rl_bitmap #(.GROUPS(GROUPS), .GROUP_W(GROUP_W), .PRIO_W(PRIO_W)) u_map (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en), .set_prio(set_prio),
        .clr_en(clr_en), .clr_prio(clr_prio),
        .grp_map(grp_map), .ready_flat(ready_flat)
    );

    rl_encoder #(.GROUPS(GROUPS), .GROUP_W(GROUP_W), .PRIO_W(PRIO_W)) u_enc (
        .grp_map(grp_map), .ready_flat(ready_flat),
        .top_prio(top_prio), .top_valid(top_valid)
    );

    rl_nest_ctr #(.CNT_W(CNT_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .inc(lock_req), .dec(unlock_req), .busy(lock_busy)
    );

    rl_nest_ctr #(.CNT_W(CNT_W)) u_nest (
        .clk(clk), .rst_n(rst_n), .inc(int_enter), .dec(int_exit), .busy(nest_busy)
    );

    assign switch_req = top_valid && (top_prio != run_prio) && !lock_busy && !nest_busy;

    p_top_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> ready_flat[top_prio]);
    p_top_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_flat & ((NUM'(1) << top_prio) - NUM'(1))) == '0);
    p_no_self_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (top_prio == run_prio) |-> !switch_req);
endmodule

// File: tb/ready_list_sched_bench.sv
`timescale 1ns/1ps
module ready_list_sched_bench;
    localparam int G = 4;
    localparam int W = 4;
    localparam int N = G * W;
    localparam int P = 4;
    localparam int C = 3;

    logic clk = 0, rst_n = 0;
    logic set_en = 0, clr_en = 0;
    logic [P-1:0] set_prio = 0, clr_prio = 0, run_prio = 0;
    logic lock_req = 0, unlock_req = 0, int_enter = 0, int_exit = 0;
    logic [G-1:0] grp_map;
    logic [P-1:0] top_prio;
    logic top_valid, switch_req;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [N-1:0] model;

    always #10 clk = ~clk;

    ready_list_sched #(.GROUPS(G), .GROUP_W(W), .CNT_W(C)) u_ready_list_sched (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_prio(set_prio),
        .clr_en(clr_en), .clr_prio(clr_prio), .run_prio(run_prio),
        .lock_req(lock_req), .unlock_req(unlock_req),
        .int_enter(int_enter), .int_exit(int_exit),
        .grp_map(grp_map), .top_prio(top_prio), .top_valid(top_valid),
        .switch_req(switch_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_top();
        for (int i = 0; i < N; i++) if (model[i]) return i;
        return 0;
    endfunction

    function automatic int exp_grp();
        int r = 0;
        for (int g = 0; g < G; g++) if (|model[g*W +: W]) r |= (1 << g);
        return r;
    endfunction

    task automatic op(input bit se, input int sp, input bit ce, input int cp);
        set_en = se; set_prio = P'(sp); clr_en = ce; clr_prio = P'(cp);
        tick();
        set_en = 0; clr_en = 0;
        if (se) model[sp] = 1'b1;
        if (ce && cp != N - 1) model[cp] = 1'b0;
    endtask

    task automatic check_map(input string req);
        chk({req, " top_prio"}, int'(top_prio), exp_top());
        chk("R2 grp_map", int'(grp_map), exp_grp());
    endtask

    task automatic strobe_cnt(input bit lk, input bit up, input bit ie, input bit ix);
        lock_req = lk; unlock_req = up; int_enter = ie; int_exit = ix;
        tick();
        lock_req = 0; unlock_req = 0; int_enter = 0; int_exit = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model = '0;
        model[N-1] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R4: reset state holds only the idle level
        chk("R4 reset top", int'(top_prio), N - 1);
        chk("R4 reset grp", int'(grp_map), 1 << (G - 1));
        chk("R3 top_valid", int'(top_valid), 1);

        // R1 R3: fill from least to most urgent, top follows each set
        for (int p = N - 2; p >= 0; p--) begin
            op(1, p, 0, 0);
            check_map("R1");
        end
        // R2: drain from most urgent, summary bits fall row by row
        for (int p = 0; p < N - 1; p++) begin
            op(0, 0, 1, p);
            check_map("R2");
        end
        // R3: every ordered pair of non-idle levels
        for (int a = 0; a < N - 1; a++) begin
            for (int b = 0; b < N - 1; b++) begin
                op(1, a, 0, 0);
                op(1, b, 0, 0);
                check_map("R3");
                op(0, 0, 1, a);
                check_map("R3");
                op(0, 0, 1, b);
            end
        end
        // R4: clear of idle is ignored
        op(0, 0, 1, N - 1);
        check_map("R4");
        chk("R4 idle kept", int'(top_prio), N - 1);

        // R5: same-level set and clear, clear wins
        op(1, 6, 1, 6);
        check_map("R5");
        chk("R5 not ready", int'(top_prio), N - 1);
        op(1, 6, 0, 0);
        op(1, 6, 1, 6);
        chk("R5 cleared", int'(top_prio), N - 1);
        op(1, 3, 0, 0);
        op(1, 5, 1, 3);
        chk("R5 both apply", int'(top_prio), 5);
        check_map("R5");

        // R6: compare with running level (top is 5)
        run_prio = 5; #1;
        chk("R6 equal no switch", int'(switch_req), 0);
        run_prio = 9; #1;
        chk("R6 lower running", int'(switch_req), 1);
        run_prio = 0; #1;
        chk("R6 unready running", int'(switch_req), 1);
        run_prio = 9;

        // R7: lock count
        strobe_cnt(1, 0, 0, 0);
        chk("R7 locked", int'(switch_req), 0);
        strobe_cnt(1, 1, 0, 0);
        chk("R7 lock+unlock hold", int'(switch_req), 0);
        strobe_cnt(0, 1, 0, 0);
        chk("R7 unlocked", int'(switch_req), 1);
        strobe_cnt(0, 1, 0, 0);
        strobe_cnt(1, 0, 0, 0);
        strobe_cnt(0, 1, 0, 0);
        chk("R7 unlock at zero ignored", int'(switch_req), 1);
        for (int i = 0; i < 9; i++) strobe_cnt(1, 0, 0, 0);
        for (int i = 0; i < 6; i++) strobe_cnt(0, 1, 0, 0);
        chk("R7 saturated still busy", int'(switch_req), 0);
        strobe_cnt(0, 1, 0, 0);
        chk("R7 saturated drained", int'(switch_req), 1);

        // R8: nesting count
        strobe_cnt(0, 0, 1, 0);
        strobe_cnt(0, 0, 1, 0);
        chk("R8 nested", int'(switch_req), 0);
        strobe_cnt(0, 0, 0, 1);
        chk("R8 still nested", int'(switch_req), 0);
        strobe_cnt(0, 0, 0, 1);
        chk("R8 left", int'(switch_req), 1);
        strobe_cnt(0, 0, 0, 1);
        strobe_cnt(0, 0, 1, 0);
        strobe_cnt(0, 0, 0, 1);
        chk("R8 exit at zero ignored", int'(switch_req), 1);
        for (int i = 0; i < 8; i++) strobe_cnt(0, 0, 1, 0);
        for (int i = 0; i < 7; i++) strobe_cnt(0, 0, 0, 1);
        chk("R8 saturated drained", int'(switch_req), 1);

        finish_run();
    end
endmodule